// File: doc/BRIEF.md
# Banked Pin Controller with Edge Capture

This block runs a set of general-purpose pins split into banks of 32. For each bank, software picks which pins it drives, raises or lowers driven pins by writing masks of ones, reads the synchronized level of every pin, and arms rising and/or falling edge capture per pin. Captured edges collect in a sticky status register that software clears by writing ones back. Any set status bit in any bank raises one shared interrupt line.

All banks sit behind one simple synchronous register port: address, write data and a write strobe, with read data returned from a register on the clock edge after the address is presented. Banks are laid out in groups of three. Each group takes its own 256-byte page, and inside a page the same register of the three banks sits in three adjacent words.

Top module: `pinbank_ctrl`

## Requirements
- R1: Bank n's registers start at byte address ((n / 3) << 8) + ((n % 3) << 2). Relative to that start, the register kinds sit at these offsets: pin level 0x00, drive enable 0x0C, raise mask 0x18, lower mask 0x24, rising arm 0x30, falling arm 0x3C, edge status 0x48 and capture gate 0x9C. A read of any other address, or of a bank beyond the configured count, returns 0. Read data appears on `bus_rdata` after the next rising clock edge.
- R2: A write to a bank's raise mask sets output bit k high for each 1 in the write data and leaves every other output bit unchanged. The raise mask reads back as 0.
- R3: A write to a bank's lower mask sets output bit k low for each 1 in the write data and leaves every other output bit unchanged. The lower mask reads back as 0.
- R4: Drive-enable bit k set to 1 asserts `pin_oe` for that pin, and 0 leaves the pin as an input. The register reads back what was written.
- R5: The pin level register returns the state of each pin after a two-flop synchronizer, whatever the pin's direction. A change on `pin_i` is not visible on a read issued in the same cycle.
- R6: A pin with its rising arm bit set records a 0-to-1 transition in its edge status bit. A 1-to-0 transition on that pin records nothing unless its falling arm bit is also set.
- R7: A pin with its falling arm bit set records a 1-to-0 transition. With both arm bits set, either transition is recorded.
- R8: An edge status bit stays 1 until a 1 is written to that bit of the status register. Zero bits in that write leave the status unchanged.
- R9: Edges are recorded only on pins whose capture-gate bit is 1. An armed edge on a gated-off pin leaves the status at 0.
- R10: If a new edge and a status write clearing the same bit land in the same cycle, the bit ends up set.
- R11: After reset all pins are inputs, all outputs are low, and every arm, status and capture-gate bit is 0. The interrupt is low.
- R12: `irq_o` is high exactly when at least one status bit in any bank is set. It rises in the same cycle the status bit is set and falls in the same cycle the last set bit is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one register per cycle |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| pin_i | input | NUM_BANKS*32 | Raw pin inputs |
| pin_o | output | NUM_BANKS*32 | Pin output values |
| pin_oe | output | NUM_BANKS*32 | Pin output enables |
| irq_o | output | 1 | Combined edge interrupt |

## Verification
A corrupted output register appears on `pin_o` in the cycle after the write. A corrupted status bit appears on `irq_o` in the same cycle and on a status read one cycle later. A broken synchronizer or edge comparator would show up three clocks after a pin change, either as a missing status bit or as an unexpected one. Mistakes in the address decode are caught by writing distinct patterns into the same register kind of all banks, including a bank on the second page, and reading each one back.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;
  localparam int BANK_W      = 32;
  localparam int GROUP_BANKS = 3;
  localparam int NUM_KINDS   = 7;                       // kinds laid out back to back
  localparam int GATE_WORD   = 'h9C >> 2;               // capture gate block
  localparam int SPAN_WORDS  = NUM_KINDS * GROUP_BANKS;

  typedef enum logic [3:0] {
    RK_LEVEL = 4'd0, RK_DIR = 4'd1, RK_SET = 4'd2, RK_CLR = 4'd3,
    RK_RISE  = 4'd4, RK_FALL = 4'd5, RK_STAT = 4'd6, RK_GATE = 4'd7,
    RK_NONE  = 4'd8
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e   kind;
    logic [1:0]  slot;
  } reg_sel_t;

  function automatic reg_sel_t decode_word(input logic [5:0] w);
    reg_sel_t r;
    r.kind = RK_NONE;
    r.slot = 2'd0;
    if (int'(w) < SPAN_WORDS) begin
      r.kind = reg_kind_e'(4'(int'(w) / GROUP_BANKS));
      r.slot = 2'(int'(w) % GROUP_BANKS);
    end else if (int'(w) >= GATE_WORD && int'(w) < GATE_WORD + GROUP_BANKS) begin
      r.kind = RK_GATE;
      r.slot = 2'(int'(w) - GATE_WORD);
    end
    return r;
  endfunction
endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] meta_q, cur_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      cur_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= raw_i;
      cur_q  <= meta_q;
      prev_q <= cur_q;
    end
  end

  assign cur_o  = cur_q;
  assign prev_o = prev_q;

  // R5: the comparison value trails the synchronized value by exactly one clock
  p_prev_trails_r5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (prev_o == $past(cur_o)));
endmodule

// File: rtl/pinbank_bank.sv
module pinbank_bank
  import pinbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  reg_kind_e         kind,
  input  logic [BANK_W-1:0] wdata,
  input  logic [BANK_W-1:0] lvl_cur,
  input  logic [BANK_W-1:0] lvl_prev,
  output logic [BANK_W-1:0] out_q,
  output logic [BANK_W-1:0] dir_q,
  output logic [BANK_W-1:0] rise_q,
  output logic [BANK_W-1:0] fall_q,
  output logic [BANK_W-1:0] stat_q,
  output logic [BANK_W-1:0] gate_q,
  output logic              stat_any_d
);
  logic [BANK_W-1:0] up_e, down_e, new_edge, clr_bits, stat_d;

  always_comb begin
    up_e     = lvl_cur & ~lvl_prev;
    down_e   = ~lvl_cur & lvl_prev;
    new_edge = gate_q & ((up_e & rise_q) | (down_e & fall_q));
    clr_bits = (wr_en && kind == RK_STAT) ? wdata : '0;
    stat_d   = (stat_q & ~clr_bits) | new_edge;   // a fresh edge beats the clear
    stat_any_d = |stat_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q  <= '0;
      dir_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
      stat_q <= '0;
      gate_q <= '0;
    end else begin
      stat_q <= stat_d;
      if (wr_en) begin
        case (kind)
          RK_DIR:  dir_q  <= wdata;
          RK_SET:  out_q  <= out_q | wdata;
          RK_CLR:  out_q  <= out_q & ~wdata;
          RK_RISE: rise_q <= wdata;
          RK_FALL: fall_q <= wdata;
          RK_GATE: gate_q <= wdata;
          default: ;
        endcase
      end
    end
  end

  p_set_high_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && kind == RK_SET) |=> ((out_q & $past(wdata)) == $past(wdata)));

  p_clr_low_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && kind == RK_CLR) |=> ((out_q & $past(wdata)) == '0));

  p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((stat_q & $past(stat_q & ~clr_bits)) == $past(stat_q & ~clr_bits)));

  p_gated_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(gate_q)) == '0));

  p_edge_wins_r10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((stat_q & $past(new_edge)) == $past(new_edge)));
endmodule

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl
  import pinbank_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 12
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [BANK_W-1:0]           bus_wdata,
  input  logic                        bus_we,
  output logic [BANK_W-1:0]           bus_rdata,
  input  logic [NUM_BANKS*BANK_W-1:0] pin_i,
  output logic [NUM_BANKS*BANK_W-1:0] pin_o,
  output logic [NUM_BANKS*BANK_W-1:0] pin_oe,
  output logic                        irq_o
);
  localparam int NPINS  = NUM_BANKS * BANK_W;
  localparam int PAGE_W = ADDR_W - 8;

  logic [NPINS-1:0]  lvl_cur, lvl_prev;
  logic [BANK_W-1:0] out_a [NUM_BANKS];
  logic [BANK_W-1:0] dir_a [NUM_BANKS];
  logic [BANK_W-1:0] rise_a[NUM_BANKS];
  logic [BANK_W-1:0] fall_a[NUM_BANKS];
  logic [BANK_W-1:0] stat_a[NUM_BANKS];
  logic [BANK_W-1:0] gate_a[NUM_BANKS];
  logic [NUM_BANKS-1:0] any_d, stat_nz;

  reg_sel_t          sel;
  logic [PAGE_W-1:0] page;
  int unsigned       sel_bank;
  logic              hit;
  logic [BANK_W-1:0] rd_d, rdata_q;
  logic              irq_q;

  pinbank_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst(rst), .raw_i(pin_i), .cur_o(lvl_cur), .prev_o(lvl_prev)
  );

  always_comb begin
    sel      = decode_word(bus_addr[7:2]);
    page     = bus_addr[ADDR_W-1:8];
    sel_bank = 32'(page) * GROUP_BANKS + 32'(sel.slot);
    hit      = (bus_addr[1:0] == 2'b00) && (sel.kind != RK_NONE) &&
               (sel_bank < NUM_BANKS);
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    pinbank_bank u_bank (
      .clk(clk), .rst(rst),
      .wr_en(bus_we && hit && (sel_bank == b)),
      .kind(sel.kind), .wdata(bus_wdata),
      .lvl_cur(lvl_cur[b*BANK_W +: BANK_W]),
      .lvl_prev(lvl_prev[b*BANK_W +: BANK_W]),
      .out_q(out_a[b]), .dir_q(dir_a[b]), .rise_q(rise_a[b]),
      .fall_q(fall_a[b]), .stat_q(stat_a[b]), .gate_q(gate_a[b]),
      .stat_any_d(any_d[b])
    );
    assign pin_o [b*BANK_W +: BANK_W] = out_a[b];
    assign pin_oe[b*BANK_W +: BANK_W] = dir_a[b];
    assign stat_nz[b] = |stat_a[b];
  end

  always_comb begin
    rd_d = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (hit && sel_bank == b) begin
        case (sel.kind)
          RK_LEVEL: rd_d = lvl_cur[b*BANK_W +: BANK_W];
          RK_DIR:   rd_d = dir_a[b];
          RK_RISE:  rd_d = rise_a[b];
          RK_FALL:  rd_d = fall_a[b];
          RK_STAT:  rd_d = stat_a[b];
          RK_GATE:  rd_d = gate_a[b];
          default:  rd_d = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      rdata_q <= rd_d;
      irq_q   <= |any_d;
    end
  end

  assign bus_rdata = rdata_q;
  assign irq_o     = irq_q;

  // R12: interrupt follows the union of all bank status registers
  p_irq_union_r12: assert property (@(posedge clk) disable iff (rst)
    irq_o == (|stat_nz));

  // R4: enables only change on a write
  p_oe_stable_r4: assert property (@(posedge clk) disable iff (rst)
    !bus_we |=> $stable(pin_oe));
endmodule

// File: tb/sim_pinbank_ctrl.sv
module sim_pinbank_ctrl;
  localparam int NB = 4;
  localparam int OF_LVL = 'h00, OF_DIR = 'h0C, OF_SET = 'h18, OF_CLR = 'h24,
                 OF_RIS = 'h30, OF_FAL = 'h3C, OF_STS = 'h48, OF_GTE = 'h9C;

  logic clk = 1'b0, rst = 1'b1;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic bus_we = 1'b0;
  logic [NB*32-1:0] pin_i = '0, pin_o, pin_oe;
  logic irq_o;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pinbank_ctrl #(.NUM_BANKS(NB), .ADDR_W(12)) u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .pin_i(pin_i), .pin_o(pin_o),
    .pin_oe(pin_oe), .irq_o(irq_o));

  function automatic logic [11:0] ra(int bank, int ofs);
    return 12'(((bank / 3) << 8) + ((bank % 3) << 2) + ofs);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R11 oe", pin_oe[31:0] | pin_oe[127:96], 32'h0);
    chk("R11 out", pin_o[63:32], 32'h0);
    chk("R11 irq", {31'b0, irq_o}, 32'h0);
    rd(ra(0, OF_DIR), v); chk("R11 dir", v, 32'h0);
    rd(ra(3, OF_STS), v); chk("R11 status", v, 32'h0);
    rd(ra(1, OF_GTE), v); chk("R11 gate", v, 32'h0);
    rd(ra(2, OF_RIS), v); chk("R11 rise", v, 32'h0);
  endtask

  task automatic t_map();
    logic [31:0] v;
    for (int b = 0; b < NB; b++) wr(ra(b, OF_DIR), 32'hA500_0000 | 32'(b * 17 + 1));
    for (int b = 0; b < NB; b++) begin
      rd(ra(b, OF_DIR), v); chk("R1 dir map", v, 32'hA500_0000 | 32'(b * 17 + 1));
      chk("R4 oe", pin_oe[b*32 +: 32], 32'hA500_0000 | 32'(b * 17 + 1));
    end
    rd(12'h060, v); chk("R1 unmapped", v, 32'h0);
    rd(12'h200, v); chk("R1 absent bank", v, 32'h0);
    for (int b = 0; b < NB; b++) wr(ra(b, OF_DIR), 32'h0);
  endtask

  task automatic t_setclr();
    logic [31:0] v;
    wr(ra(1, OF_SET), 32'h0000_00F0); chk("R2 set", pin_o[63:32], 32'h0000_00F0);
    wr(ra(1, OF_SET), 32'h0000_000F); chk("R2 set keeps", pin_o[63:32], 32'h0000_00FF);
    wr(ra(1, OF_CLR), 32'h0000_0030); chk("R3 clear", pin_o[63:32], 32'h0000_00CF);
    wr(ra(1, OF_CLR), 32'h0);         chk("R3 zero clear", pin_o[63:32], 32'h0000_00CF);
    rd(ra(1, OF_SET), v); chk("R2 readback", v, 32'h0);
    rd(ra(1, OF_CLR), v); chk("R3 readback", v, 32'h0);
    chk("R2 other bank", pin_o[31:0], 32'h0);
  endtask

  task automatic t_level();
    logic [31:0] v;
    pin_i[95:64] = 32'h1234_5678;
    rd(ra(2, OF_LVL), v); chk("R5 latency", v, 32'h0);
    settle();
    rd(ra(2, OF_LVL), v); chk("R5 level", v, 32'h1234_5678);
    wr(ra(2, OF_DIR), 32'hFFFF_FFFF);
    rd(ra(2, OF_LVL), v); chk("R5 level as output", v, 32'h1234_5678);
    wr(ra(2, OF_DIR), 32'h0);
  endtask

  task automatic t_rise();
    logic [31:0] v;
    wr(ra(0, OF_GTE), 32'hFFFF_FFFF);
    wr(ra(0, OF_RIS), 32'h1);
    pin_i[0] = 1'b1; settle();
    rd(ra(0, OF_STS), v); chk("R6 rise", v, 32'h1);
    chk("R12 irq up", {31'b0, irq_o}, 32'h1);
    wr(ra(0, OF_STS), 32'h1);
    chk("R12 irq down", {31'b0, irq_o}, 32'h0);
    pin_i[0] = 1'b0; settle();
    rd(ra(0, OF_STS), v); chk("R6 fall ignored", v, 32'h0);
  endtask

  task automatic t_fall();
    logic [31:0] v;
    wr(ra(0, OF_FAL), 32'h6);
    wr(ra(0, OF_RIS), 32'h5);
    pin_i[1] = 1'b1; settle();
    rd(ra(0, OF_STS), v); chk("R7 rise unarmed", v, 32'h0);
    pin_i[1] = 1'b0; settle();
    rd(ra(0, OF_STS), v); chk("R7 fall", v, 32'h2);
    wr(ra(0, OF_STS), 32'h2);
    pin_i[2] = 1'b1; settle();
    rd(ra(0, OF_STS), v); chk("R7 both up", v, 32'h4);
    wr(ra(0, OF_STS), 32'h4);
    pin_i[2] = 1'b0; settle();
    rd(ra(0, OF_STS), v); chk("R7 both down", v, 32'h4);
    wr(ra(0, OF_STS), 32'h4);
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    pin_i[2] = 1'b1; pin_i[0] = 1'b1; settle();
    rd(ra(0, OF_STS), v); chk("R8 two set", v, 32'h5);
    wr(ra(0, OF_STS), 32'h0);
    rd(ra(0, OF_STS), v); chk("R8 zero write", v, 32'h5);
    wr(ra(0, OF_STS), 32'h4);
    rd(ra(0, OF_STS), v); chk("R8 one cleared", v, 32'h1);
    wr(ra(0, OF_STS), 32'h1);
    rd(ra(0, OF_STS), v); chk("R8 all cleared", v, 32'h0);
  endtask

  task automatic t_gate();
    logic [31:0] v;
    wr(ra(1, OF_RIS), 32'hFFFF_FFFF);
    pin_i[32+4] = 1'b1; settle();
    rd(ra(1, OF_STS), v); chk("R9 gated off", v, 32'h0);
    chk("R9 no irq", {31'b0, irq_o}, 32'h0);
    wr(ra(1, OF_GTE), 32'h10);
    pin_i[32+4] = 1'b0; settle();
    pin_i[32+4] = 1'b1; pin_i[32+5] = 1'b1; settle();
    rd(ra(1, OF_STS), v); chk("R9 gated on", v, 32'h10);
    wr(ra(1, OF_STS), 32'hFFFF_FFFF);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    pin_i[2] = 1'b0; settle();
    rd(ra(0, OF_STS), v); chk("R10 setup", v, 32'h4);
    pin_i[2] = 1'b1;
    @(negedge clk); @(negedge clk);
    wr(ra(0, OF_STS), 32'h4);
    rd(ra(0, OF_STS), v); chk("R10 edge wins", v, 32'h4);
    wr(ra(0, OF_STS), 32'h4);
    rd(ra(0, OF_STS), v); chk("R10 later clear", v, 32'h0);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    chk("R12 idle", {31'b0, irq_o}, 32'h0);
    wr(ra(3, OF_GTE), 32'hFFFF_FFFF);
    wr(ra(3, OF_FAL), 32'h8000_0000);
    pin_i[127] = 1'b1; settle();
    chk("R12 no edge", {31'b0, irq_o}, 32'h0);
    pin_i[127] = 1'b0; settle();
    rd(12'h148, v); chk("R1 second page status", v, 32'h8000_0000);
    chk("R12 bank3 irq", {31'b0, irq_o}, 32'h1);
    wr(12'h148, 32'h8000_0000);
    chk("R12 cleared", {31'b0, irq_o}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_map();
    t_setclr();
    t_level();
    t_rise();
    t_fall();
    t_w1c();
    t_gate();
    t_collide();
    t_irq();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule